// File: doc/BRIEF.md
# Multithreaded Reorder Buffer Allocator

This block is the occupancy and ordering core of a reorder buffer shared by several hardware threads of a simultaneously multithreaded core. Each thread owns an in-order circular queue of instruction tags, where a tag is a sequence number plus a ready flag. A sharing policy caps how many entries each thread may hold at once. The policy is chosen at reset from three options: every thread may use the whole buffer, the buffer is split evenly, or a fixed threshold applies. The caps are recomputed each time the scheduler reports a new set of active threads.

Dispatch logic inserts a tag into a thread's queue and learns the slot it landed in. Execution logic later marks that slot ready through a separate update port. Commit logic retires the front of a chosen thread once it is ready. Every cycle the block publishes a free count for each thread and for the whole buffer, a per-thread head-ready flag, a can-commit summary, and the global head and global tail. The global head is the oldest thread front and the global tail is the youngest thread back, both found by comparing sequence numbers across the active threads.

Top module: `smt_rob_alloc`

## Requirements
- R1: While and after reset, every thread queue is empty: the global free count equals the total entry count, no head is ready, can-commit is low, and the global head and tail are both invalid.
- R2: With policy code 0 (shared), every configured thread slot (index below `cfg_threads`) has a cap equal to the total entry count. Slots at or above `cfg_threads` have a cap of zero under every policy.
- R3: With policy code 1 (even split), each configured thread's cap is the total divided by `cfg_threads`, rounded down.
- R4: With policy code 2 (fixed limit), each configured thread's cap is `cfg_threshold`, clamped to the total. Policy code 3 behaves as code 0.
- R5: A pulse on `active_change` recomputes caps over the live threads (active and configured). Under code 1 each live thread gets the total divided by the live count, and a live count of zero leaves the caps unchanged. Under code 2 with exactly one live thread, that thread gets the full total. All other caps keep their value.
- R6: A thread's free count is its cap minus its occupancy, or zero when the occupancy exceeds the cap. The global free count is the total minus the summed occupancy.
- R7: An insert is refused with `ins_err` high in the same cycle, and leaves all state unchanged, when the thread is at or above its cap or the buffer is full. An accepted insert appends at the thread's back, and `ins_slot` reports the slot index it was written to.
- R8: A retire removes the front entry of the named thread only if that entry is ready. Otherwise `ret_err` is high in the same cycle and nothing changes.
- R9: A mark sets the ready flag of the given thread and slot. `head_ready[t]` is high when thread t is non-empty and its front is ready. `can_commit` is high when some live thread has a ready head.
- R10: The global head is the front with the lowest sequence number among non-empty live threads. Ties go to the lower thread index. It is invalid when no such thread exists.
- R11: The global tail is the back with the highest sequence number among non-empty live threads. Ties go to the lower thread index. It is valid exactly when the global head is valid.
- R12: Each thread queue wraps around its slot range and keeps first-in first-out order over any number of inserts and retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads base caps from the configuration |
| cfg_policy | input | 2 | Sharing policy code: 0 shared, 1 even split, 2 fixed limit, 3 as 0 |
| cfg_threads | input | $clog2(NT+1) | Number of configured thread slots |
| cfg_threshold | input | $clog2(TOTAL+1) | Per-thread limit for policy code 2 |
| active_mask | input | NT | Threads currently active |
| active_change | input | 1 | Pulse: active set changed, recompute caps |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | $clog2(NT) | Thread to insert into |
| ins_seq | input | SEQ_W | Sequence number of the inserted tag |
| ins_err | output | 1 | Insert refused this cycle |
| ins_slot | output | $clog2(TOTAL) | Slot the insert lands in |
| ret_valid | input | 1 | Retire request |
| ret_tid | input | $clog2(NT) | Thread whose front is retired |
| ret_err | output | 1 | Retire refused this cycle |
| mark_valid | input | 1 | Ready-flag update request |
| mark_tid | input | $clog2(NT) | Thread of the update |
| mark_slot | input | $clog2(TOTAL) | Slot of the update |
| head_ready | output | NT | Per-thread front-ready flags |
| can_commit | output | 1 | Some live thread has a ready front |
| thread_free | output | NT*$clog2(TOTAL+1) | Per-thread free counts, thread t at bits t*W |
| global_free | output | $clog2(TOTAL+1) | Free entries in the whole buffer |
| ghead_valid | output | 1 | Global head exists |
| ghead_tid | output | $clog2(NT) | Thread holding the global head |
| ghead_seq | output | SEQ_W | Sequence number of the global head |
| gtail_valid | output | 1 | Global tail exists |
| gtail_tid | output | $clog2(NT) | Thread holding the global tail |
| gtail_seq | output | SEQ_W | Sequence number of the global tail |

## Verification
A corrupted occupancy counter or cap register shows up at once in the free counts and in the accept or refuse decision of the very next insert. A read or write pointer that drifts shows up as a wrong `ins_slot`, or as a global head whose sequence number breaks arrival order, within the cycle after the bad update. An error in the age comparison shows up as the wrong thread index in the global head or tail as soon as two live threads are non-empty. The directed scenarios therefore read the ports right after each single operation, so that each fault is caught in the cycle it first appears.

// File: rtl/smt_rob_pkg.sv
`timescale 1ns/1ps
package smt_rob_pkg;

   typedef enum logic [1:0] {
      POL_SHARED    = 2'd0,
      POL_SPLIT     = 2'd1,
      POL_LIMIT     = 2'd2,
      POL_RESERVED  = 2'd3
   } share_pol_e;

endpackage

// File: rtl/rob_thread_queue.sv
`timescale 1ns/1ps
module rob_thread_queue #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned SEQ_W = 16,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic [SEQ_W-1:0] push_seq,
   input  logic             pop_en,
   input  logic             mark_en,
   input  logic [PW-1:0]    mark_idx,
   output logic [CW-1:0]    count,
   output logic [SEQ_W-1:0] front_seq,
   output logic             front_rdy,
   output logic [SEQ_W-1:0] back_seq,
   output logic [PW-1:0]    next_slot
);

   logic [SEQ_W-1:0] seq_q [DEPTH];
   logic [DEPTH-1:0] rdy_q;
   logic [PW-1:0]    rd_ptr;
   logic [PW-1:0]    wr_ptr;
   logic [CW-1:0]    cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
         rdy_q  <= '0;
      end else begin
         if (mark_en) rdy_q[mark_idx] <= 1'b1;
         if (push_en) begin
            rdy_q[wr_ptr] <= 1'b0;
            wr_ptr        <= wr_ptr + PW'(1);
         end
         if (pop_en) rd_ptr <= rd_ptr + PW'(1);
         cnt_q <= cnt_q + CW'(push_en) - CW'(pop_en);
      end
   end

   always_ff @(posedge clk) begin
      if (push_en) seq_q[wr_ptr] <= push_seq;
   end

   assign count     = cnt_q;
   assign front_seq = seq_q[rd_ptr];
   assign front_rdy = (cnt_q != '0) && rdy_q[rd_ptr];
   assign back_seq  = seq_q[wr_ptr - PW'(1)];
   assign next_slot = wr_ptr;

   // R12
   occupancy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R8
   pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> (cnt_q != '0));

endmodule

// File: rtl/rob_cap_ctrl.sv
`timescale 1ns/1ps
module rob_cap_ctrl
   import smt_rob_pkg::*;
#(
   parameter int unsigned NT    = 4,
   parameter int unsigned TOTAL = 16,
   localparam int unsigned CW   = $clog2(TOTAL + 1),
   localparam int unsigned TCW  = $clog2(NT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_policy,
   input  logic [TCW-1:0]  cfg_threads,
   input  logic [CW-1:0]   cfg_threshold,
   input  logic [NT-1:0]   active_mask,
   input  logic            active_change,
   output logic [NT*CW-1:0] cap_flat,
   output logic [NT-1:0]   live_mask
);

   share_pol_e      pol;
   logic [NT-1:0]   cfg_mask;
   logic [CW-1:0]   split_cfg;
   logic [CW-1:0]   split_live;
   logic [CW-1:0]   limit_val;
   int unsigned     live_cnt;
   logic [CW-1:0]   base_cap [NT];
   logic [CW-1:0]   cap_q    [NT];
   logic [CW-1:0]   cap_nx   [NT];

   assign pol = share_pol_e'(cfg_policy);

   always_comb begin
      for (int t = 0; t < NT; t++) cfg_mask[t] = (t < int'(cfg_threads));
   end

   assign live_mask = active_mask & cfg_mask;
   assign live_cnt  = $countones(live_mask);

   assign split_cfg  = (cfg_threads == '0) ? '0 : CW'(TOTAL / int'(cfg_threads));
   assign split_live = (live_cnt == 0) ? '0 : CW'(TOTAL / live_cnt);
   assign limit_val  = (cfg_threshold > CW'(TOTAL)) ? CW'(TOTAL) : cfg_threshold;

   always_comb begin
      for (int t = 0; t < NT; t++) begin
         base_cap[t] = '0;
         if (cfg_mask[t]) begin
            case (pol)
               POL_SPLIT: base_cap[t] = split_cfg;
               POL_LIMIT: base_cap[t] = limit_val;
               default:   base_cap[t] = CW'(TOTAL);
            endcase
         end
      end
   end

   always_comb begin
      for (int t = 0; t < NT; t++) begin
         cap_nx[t] = cap_q[t];
         if (active_change && live_mask[t]) begin
            if (pol == POL_SPLIT && live_cnt != 0) cap_nx[t] = split_live;
            else if (pol == POL_LIMIT && live_cnt == 1) cap_nx[t] = CW'(TOTAL);
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int t = 0; t < NT; t++) begin
         if (!rst_n) cap_q[t] <= base_cap[t];
         else        cap_q[t] <= cap_nx[t];
      end
   end

   generate
      for (genvar g = 0; g < NT; g++) begin : g_cap
         assign cap_flat[g*CW +: CW] = cap_q[g];

         // R2
         idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_mask[g] |-> (cap_q[g] == '0));
      end
   endgenerate

   // R5
   hold_caps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_change |=> $stable(cap_flat));

endmodule

// File: rtl/rob_age_pick.sv
`timescale 1ns/1ps
module rob_age_pick #(
   parameter int unsigned NT          = 4,
   parameter int unsigned SEQ_W       = 16,
   parameter bit          PICK_OLDEST = 1'b1,
   localparam int unsigned TIDW       = $clog2(NT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NT-1:0]     cand,
   input  logic [NT*SEQ_W-1:0] seq_flat,
   output logic              found,
   output logic [TIDW-1:0]   pick_tid,
   output logic [SEQ_W-1:0]  pick_seq
);

   generate
      if (PICK_OLDEST) begin : g_oldest
         always_comb begin
            found    = 1'b0;
            pick_tid = '0;
            pick_seq = '0;
            for (int t = 0; t < NT; t++) begin
               if (cand[t] && (!found || seq_flat[t*SEQ_W +: SEQ_W] < pick_seq)) begin
                  found    = 1'b1;
                  pick_tid = TIDW'(t);
                  pick_seq = seq_flat[t*SEQ_W +: SEQ_W];
               end
            end
         end
      end else begin : g_youngest
         always_comb begin
            found    = 1'b0;
            pick_tid = '0;
            pick_seq = '0;
            for (int t = 0; t < NT; t++) begin
               if (cand[t] && (!found || seq_flat[t*SEQ_W +: SEQ_W] > pick_seq)) begin
                  found    = 1'b1;
                  pick_tid = TIDW'(t);
                  pick_seq = seq_flat[t*SEQ_W +: SEQ_W];
               end
            end
         end
      end
   endgenerate

   // R10
   pick_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> cand[pick_tid]);

endmodule

// File: rtl/smt_rob_alloc.sv
`timescale 1ns/1ps
module smt_rob_alloc #(
   parameter int unsigned NT    = 4,
   parameter int unsigned TOTAL = 16,
   parameter int unsigned SEQ_W = 16,
   localparam int unsigned TIDW = $clog2(NT),
   localparam int unsigned PW   = $clog2(TOTAL),
   localparam int unsigned CW   = $clog2(TOTAL + 1),
   localparam int unsigned TCW  = $clog2(NT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_policy,
   input  logic [TCW-1:0]    cfg_threads,
   input  logic [CW-1:0]     cfg_threshold,
   input  logic [NT-1:0]     active_mask,
   input  logic              active_change,
   input  logic              ins_valid,
   input  logic [TIDW-1:0]   ins_tid,
   input  logic [SEQ_W-1:0]  ins_seq,
   output logic              ins_err,
   output logic [PW-1:0]     ins_slot,
   input  logic              ret_valid,
   input  logic [TIDW-1:0]   ret_tid,
   output logic              ret_err,
   input  logic              mark_valid,
   input  logic [TIDW-1:0]   mark_tid,
   input  logic [PW-1:0]     mark_slot,
   output logic [NT-1:0]     head_ready,
   output logic              can_commit,
   output logic [NT*CW-1:0]  thread_free,
   output logic [CW-1:0]     global_free,
   output logic              ghead_valid,
   output logic [TIDW-1:0]   ghead_tid,
   output logic [SEQ_W-1:0]  ghead_seq,
   output logic              gtail_valid,
   output logic [TIDW-1:0]   gtail_tid,
   output logic [SEQ_W-1:0]  gtail_seq
);

   generate
      if (NT < 2 || (1 << TIDW) != NT) begin : g_bad_nt
         $error("thread count must be a power of two, at least 2");
      end
      if (TOTAL < NT || (1 << PW) != TOTAL) begin : g_bad_total
         $error("entry count must be a power of two, not below thread count");
      end
      if (SEQ_W < 2) begin : g_bad_seq
         $error("sequence width too small");
      end
   endgenerate

   logic [NT*CW-1:0]    cap_flat;
   logic [NT-1:0]       live_mask;
   logic [CW-1:0]       cap     [NT];
   logic [CW-1:0]       occ     [NT];
   logic [PW-1:0]       nslot   [NT];
   logic [NT-1:0]       push_v;
   logic [NT-1:0]       pop_v;
   logic [NT-1:0]       mark_v;
   logic [NT-1:0]       nonempty;
   logic [NT*SEQ_W-1:0] front_flat;
   logic [NT*SEQ_W-1:0] back_flat;
   logic [CW-1:0]       occ_sum;
   logic                ins_room;

   rob_cap_ctrl #(.NT(NT), .TOTAL(TOTAL)) u_caps (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_policy    (cfg_policy),
      .cfg_threads   (cfg_threads),
      .cfg_threshold (cfg_threshold),
      .active_mask   (active_mask),
      .active_change (active_change),
      .cap_flat      (cap_flat),
      .live_mask     (live_mask)
   );

   always_comb begin
      occ_sum = '0;
      for (int t = 0; t < NT; t++) occ_sum = occ_sum + occ[t];
   end

   assign ins_room = (occ[ins_tid] < cap[ins_tid]) && (occ_sum != CW'(TOTAL));
   assign ins_err  = ins_valid && !ins_room;
   assign ins_slot = nslot[ins_tid];
   assign ret_err  = ret_valid && !head_ready[ret_tid];
   assign global_free = CW'(TOTAL) - occ_sum;
   assign can_commit  = |(head_ready & live_mask);

   generate
      for (genvar g = 0; g < NT; g++) begin : g_thr
         assign cap[g]      = cap_flat[g*CW +: CW];
         assign push_v[g]   = ins_valid && ins_room && (ins_tid == TIDW'(g));
         assign pop_v[g]    = ret_valid && head_ready[g] && (ret_tid == TIDW'(g));
         assign mark_v[g]   = mark_valid && (mark_tid == TIDW'(g));
         assign nonempty[g] = (occ[g] != '0);
         assign thread_free[g*CW +: CW] = (cap[g] > occ[g]) ? (cap[g] - occ[g]) : '0;

         rob_thread_queue #(.DEPTH(TOTAL), .SEQ_W(SEQ_W)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_en   (push_v[g]),
            .push_seq  (ins_seq),
            .pop_en    (pop_v[g]),
            .mark_en   (mark_v[g]),
            .mark_idx  (mark_slot),
            .count     (occ[g]),
            .front_seq (front_flat[g*SEQ_W +: SEQ_W]),
            .front_rdy (head_ready[g]),
            .back_seq  (back_flat[g*SEQ_W +: SEQ_W]),
            .next_slot (nslot[g])
         );
      end
   endgenerate

   rob_age_pick #(.NT(NT), .SEQ_W(SEQ_W), .PICK_OLDEST(1'b1)) u_head (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand     (nonempty & live_mask),
      .seq_flat (front_flat),
      .found    (ghead_valid),
      .pick_tid (ghead_tid),
      .pick_seq (ghead_seq)
   );

   rob_age_pick #(.NT(NT), .SEQ_W(SEQ_W), .PICK_OLDEST(1'b0)) u_tail (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand     (nonempty & live_mask),
      .seq_flat (back_flat),
      .found    (gtail_valid),
      .pick_tid (gtail_tid),
      .pick_seq (gtail_seq)
   );

   // R7
   reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_err && !ret_valid |=> global_free == $past(global_free));

   // R8
   retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && !ret_err && !ins_valid |=> global_free == $past(global_free) + CW'(1));

   // R11
   ends_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ghead_valid == gtail_valid);

   // R6
   free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      global_free <= CW'(TOTAL));

endmodule

// File: tb/smt_rob_alloc_test.sv
`timescale 1ns/1ps
module smt_rob_alloc_test;

   localparam int NT    = 4;
   localparam int TOTAL = 16;
   localparam int SEQ_W = 16;
   localparam int TIDW  = 2;
   localparam int PW    = 4;
   localparam int CW    = 5;
   localparam int TCW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]       cfg_policy = '0;
   logic [TCW-1:0]   cfg_threads = TCW'(4);
   logic [CW-1:0]    cfg_threshold = '0;
   logic [NT-1:0]    active_mask = '1;
   logic             active_change = 1'b0;
   logic             ins_valid = 1'b0;
   logic [TIDW-1:0]  ins_tid = '0;
   logic [SEQ_W-1:0] ins_seq = '0;
   logic             ins_err;
   logic [PW-1:0]    ins_slot;
   logic             ret_valid = 1'b0;
   logic [TIDW-1:0]  ret_tid = '0;
   logic             ret_err;
   logic             mark_valid = 1'b0;
   logic [TIDW-1:0]  mark_tid = '0;
   logic [PW-1:0]    mark_slot = '0;
   logic [NT-1:0]    head_ready;
   logic             can_commit;
   logic [NT*CW-1:0] thread_free;
   logic [CW-1:0]    global_free;
   logic             ghead_valid, gtail_valid;
   logic [TIDW-1:0]  ghead_tid, gtail_tid;
   logic [SEQ_W-1:0] ghead_seq, gtail_seq;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   smt_rob_alloc #(.NT(NT), .TOTAL(TOTAL), .SEQ_W(SEQ_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .cfg_threads(cfg_threads),
      .cfg_threshold(cfg_threshold), .active_mask(active_mask), .active_change(active_change),
      .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq), .ins_err(ins_err),
      .ins_slot(ins_slot), .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_err(ret_err),
      .mark_valid(mark_valid), .mark_tid(mark_tid), .mark_slot(mark_slot),
      .head_ready(head_ready), .can_commit(can_commit), .thread_free(thread_free),
      .global_free(global_free), .ghead_valid(ghead_valid), .ghead_tid(ghead_tid),
      .ghead_seq(ghead_seq), .gtail_valid(gtail_valid), .gtail_tid(gtail_tid),
      .gtail_seq(gtail_seq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int tfree(input int t);
      return int'(thread_free[t*CW +: CW]);
   endfunction

   task automatic do_reset(input int pol, input int thr, input int lim);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_policy = 2'(pol);
      cfg_threads = TCW'(thr);
      cfg_threshold = CW'(lim);
      active_mask = '1;
      ins_valid = 1'b0; ret_valid = 1'b0; mark_valid = 1'b0; active_change = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic push(input int tid, input int seq, output int err, output int slot);
      @(negedge clk);
      ins_valid = 1'b1; ins_tid = TIDW'(tid); ins_seq = SEQ_W'(seq);
      #1;
      err = int'(ins_err);
      slot = int'(ins_slot);
      @(posedge clk);
      #1 ins_valid = 1'b0;
   endtask

   task automatic retire(input int tid, output int err);
      @(negedge clk);
      ret_valid = 1'b1; ret_tid = TIDW'(tid);
      #1 err = int'(ret_err);
      @(posedge clk);
      #1 ret_valid = 1'b0;
   endtask

   task automatic mark(input int tid, input int slot);
      @(negedge clk);
      mark_valid = 1'b1; mark_tid = TIDW'(tid); mark_slot = PW'(slot);
      @(posedge clk);
      #1 mark_valid = 1'b0;
   endtask

   task automatic set_active(input logic [NT-1:0] m, input bit pulse);
      @(negedge clk);
      active_mask = m;
      active_change = pulse;
      @(posedge clk);
      #1 active_change = 1'b0;
   endtask

   task automatic t_reset;
      do_reset(0, 4, 0);
      chk("R1 global_free", int'(global_free), 16);
      chk("R1 ghead_valid", int'(ghead_valid), 0);
      chk("R1 gtail_valid", int'(gtail_valid), 0);
      chk("R1 can_commit", int'(can_commit), 0);
      chk("R1 head_ready", int'(head_ready), 0);
   endtask

   task automatic t_shared_slots;
      int e, s;
      do_reset(0, 3, 0);
      chk("R2 free t0 shared", tfree(0), 16);
      chk("R2 free t3 unconfigured", tfree(3), 0);
      push(3, 7, e, s);
      chk("R7 insert into zero-cap slot", e, 1);
      chk("R7 state unchanged", int'(global_free), 16);
   endtask

   task automatic t_split;
      int e, s;
      do_reset(1, 3, 0);
      chk("R3 free t0 split", tfree(0), 5);
      chk("R3 free t2 split", tfree(2), 5);
      for (int i = 0; i < 5; i++) begin
         push(0, i + 1, e, s);
         chk("R7 accepted insert", e, 0);
         chk("R7 slot index", s, i);
      end
      push(0, 9, e, s);
      chk("R7 thread at cap", e, 1);
      chk("R6 free t0 zero", tfree(0), 0);
      chk("R6 global_free", int'(global_free), 11);
   endtask

   task automatic t_limit;
      do_reset(2, 4, 6);
      chk("R4 free t1 limit", tfree(1), 6);
      set_active(4'b0010, 1'b1);
      chk("R5 single live gets total", tfree(1), 16);
      chk("R5 other keeps limit", tfree(0), 6);
      do_reset(2, 4, 25);
      chk("R4 limit clamped", tfree(3), 16);
      do_reset(3, 4, 0);
      chk("R4 code 3 as shared", tfree(2), 16);
   endtask

   task automatic t_resplit;
      int e, s;
      do_reset(1, 4, 0);
      chk("R3 split by four", tfree(0), 4);
      set_active(4'b0011, 1'b1);
      chk("R5 split live t0", tfree(0), 8);
      chk("R5 non-live kept", tfree(2), 4);
      set_active(4'b0000, 1'b1);
      chk("R5 zero live unchanged", tfree(0), 8);
      set_active(4'b0001, 1'b1);
      chk("R5 single live split", tfree(0), 16);
      for (int i = 0; i < 10; i++) push(0, 50 + i, e, s);
      set_active(4'b1111, 1'b1);
      chk("R6 free saturates", tfree(0), 0);
      chk("R6 global after fill", int'(global_free), 6);
   endtask

   task automatic t_age_and_retire;
      int e, s;
      do_reset(0, 4, 0);
      push(1, 10, e, s);
      push(0, 20, e, s);
      push(2, 5, e, s);
      push(2, 30, e, s);
      chk("R10 head tid", int'(ghead_tid), 2);
      chk("R10 head seq", int'(ghead_seq), 5);
      chk("R11 tail tid", int'(gtail_tid), 2);
      chk("R11 tail seq", int'(gtail_seq), 30);
      set_active(4'b1011, 1'b0);
      chk("R10 head skips inactive", int'(ghead_seq), 10);
      chk("R11 tail skips inactive", int'(gtail_tid), 0);
      push(3, 20, e, s);
      chk("R11 tie lower tid", int'(gtail_tid), 0);
      set_active(4'b1111, 1'b0);
      retire(2, e);
      chk("R8 retire not ready", e, 1);
      chk("R8 head kept", int'(ghead_seq), 5);
      chk("R9 head_ready low", int'(head_ready[2]), 0);
      chk("R9 can_commit low", int'(can_commit), 0);
      mark(2, 0);
      chk("R9 head_ready after mark", int'(head_ready[2]), 1);
      chk("R9 can_commit after mark", int'(can_commit), 1);
      retire(2, e);
      chk("R8 retire ready", e, 0);
      chk("R8 global_free after retire", int'(global_free), 12);
      chk("R10 new head", int'(ghead_seq), 10);
      mark(1, 0);
      set_active(4'b1101, 1'b0);
      chk("R9 head_ready of inactive", int'(head_ready[1]), 1);
      chk("R9 can_commit ignores inactive", int'(can_commit), 0);
      set_active(4'b1111, 1'b0);
   endtask

   task automatic t_wrap;
      int e, s;
      do_reset(0, 4, 0);
      push(3, 100, e, s);
      push(3, 101, e, s);
      push(3, 102, e, s);
      for (int k = 0; k < 20; k++) begin
         mark(3, k % 16);
         retire(3, e);
         chk("R12 retire in wrap", e, 0);
         chk("R12 fifo order", int'(ghead_seq), 101 + k);
         push(3, 103 + k, e, s);
         chk("R12 wrapped slot", s, (3 + k) % 16);
      end
   endtask

   task automatic t_global_full;
      int e, s;
      do_reset(0, 4, 0);
      for (int t = 0; t < 4; t++)
         for (int i = 0; i < 4; i++) push(t, t * 4 + i, e, s);
      chk("R6 global_free full", int'(global_free), 0);
      chk("R6 thread free shared", tfree(0), 12);
      push(0, 99, e, s);
      chk("R7 buffer full refused", e, 1);
      chk("R7 full unchanged", int'(global_free), 0);
      chk("R11 tail at full", int'(gtail_seq), 15);
   endtask

   initial begin
      #(8 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_shared_slots();
      t_split();
      t_limit();
      t_resplit();
      t_age_and_retire();
      t_wrap();
      t_global_full();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule